// File: doc/BRIEF.md
# Edge Boundary Mask Generator

This block turns a pair of byte addresses into a partial-store enable mask. The mask covers one aligned 8-byte block and marks the elements that lie between a start address and an end address. Elements are 8, 16 or 32 bits wide, and the mask is numbered either big-endian or little-endian. A store unit uses the mask when it writes the first and last blocks of a buffer that does not start or end on a block boundary.

A 4-bit operation code selects the element size, the endianness and whether condition flags are produced. When flags are requested, the block also reports the negative, zero, overflow and carry flags of the start address minus the end address. It gives them for both a 32-bit and a 64-bit view of that difference. A 32-bit address mode ignores the upper half of both addresses when the mask is formed. All outputs are registered and appear one cycle after the request.

Top module: `edge_mask_gen`

## Requirements
- R1: The operation code is decoded as follows. Bit 0 set suppresses the flags, and bit 1 set selects little-endian numbering. Bits 3:2 select the element size: 00 is 8-bit, 01 is 16-bit and 10 is 32-bit.
- R2: 8-bit big-endian uses the start offset s = addr_a[2:0] and the end offset e = addr_b[2:0]. The left mask is 0xFF>>s. The right mask is the low 8 bits of 0xFF<<(7-e). Element k sits at mask bit 7-k.
- R3: 8-bit little-endian uses the same offsets. The left mask is the low 8 bits of 0xFF<<s, and the right mask is 0xFF>>(7-e). Element k sits at mask bit k.
- R4: 16-bit elements take their index from address bits 2:1 and give a 4-bit mask. Big-endian left masks are F,7,3,1 and right masks are 8,C,E,F. Little-endian left masks are F,E,C,8 and right masks are 1,3,7,F.
- R5: 32-bit elements take their index from address bit 2 and give a 2-bit mask. Big-endian left masks are 3,1 and right masks are 2,3. Little-endian left masks are 3,2 and right masks are 1,3.
- R6: If the two addresses differ above bit 2, mask_out is the left mask alone.
- R7: If the two addresses agree above bit 2, mask_out is the left mask ANDed with the right mask. mask_out is the mask zero-extended to 64 bits.
- R8: When addr32 is 1, bits 63:32 of both addresses are treated as zero for the mask and for the block comparison.
- R9: A flag variant raises flags_valid and reports flags for addr_a minus addr_b on the full, unmasked addresses. flags64 holds {N,Z,V,C} of the 64-bit difference, and flags32 holds the same flags for the low 32 bits. C is set when the unsigned subtraction borrows.
- R10: A variant with bit 0 set leaves flags_valid low and drives flags32 and flags64 to zero.
- R11: Size code 11 behaves as 8-bit big-endian, whatever the value of bit 1.
- R12: Outputs follow in_valid by exactly one cycle. out_valid is high in that cycle only.
- R13: After reset, out_valid, flags_valid, mask_out and both flag fields are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op | input | 4 | Variant: {size[1:0], little_endian, no_flags} |
| addr32 | input | 1 | 32-bit address mode |
| addr_a | input | 64 | Start address |
| addr_b | input | 64 | End address |
| out_valid | output | 1 | Result strobe |
| mask_out | output | 64 | Zero-extended element mask |
| flags_valid | output | 1 | Flags present this cycle |
| flags32 | output | 4 | {N,Z,V,C} of the low 32-bit difference |
| flags64 | output | 4 | {N,Z,V,C} of the 64-bit difference |

## Verification
The hardest case to reach is two addresses that fall in the same block only because 32-bit mode discards differing upper halves. In that case the mask must be the intersection, while the flags must still reflect the full difference. The bench drives such a pair with addr32 set and then clear, and expects the mask to change from intersection to left-only while the flags stay the same. Every offset pair is also swept in both the same-block and the different-block position, for each size and each endianness. This covers the empty intersection that appears when the end offset lies before the start offset.

// File: rtl/edge_mask_gen.sv
module edge_mask_gen #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [3:0]    op,
  input  logic          addr32,
  input  logic [AW-1:0] addr_a,
  input  logic [AW-1:0] addr_b,
  output logic          out_valid,
  output logic [AW-1:0] mask_out,
  output logic          flags_valid,
  output logic [3:0]    flags32,
  output logic [3:0]    flags64
);
  localparam int HW = AW / 2;

  logic [AW-1:0] a_eff, b_eff;
  logic [7:0]    left, right, mask8;
  logic [3:0]    l4, r4;
  logic [1:0]    l2, r2;
  logic          le, same_blk;
  logic [1:0]    size;

  assign a_eff    = addr32 ? {{HW{1'b0}}, addr_a[HW-1:0]} : addr_a;
  assign b_eff    = addr32 ? {{HW{1'b0}}, addr_b[HW-1:0]} : addr_b;
  assign size     = (op[3:2] == 2'b11) ? 2'b00 : op[3:2];
  assign le       = (op[3:2] == 2'b11) ? 1'b0 : op[1];
  assign same_blk = (a_eff[AW-1:3] == b_eff[AW-1:3]);

  always_comb begin
    l4 = 4'h0; r4 = 4'h0; l2 = 2'h0; r2 = 2'h0;
    left = 8'h00; right = 8'h00;
    case (size)
      2'b01: begin
        if (le) begin
          l4 = 4'hF << a_eff[2:1];
          r4 = 4'hF >> (2'd3 - b_eff[2:1]);
        end else begin
          l4 = 4'hF >> a_eff[2:1];
          r4 = 4'hF << (2'd3 - b_eff[2:1]);
        end
        left  = {4'h0, l4};
        right = {4'h0, r4};
      end
      2'b10: begin
        if (le) begin
          l2 = a_eff[2] ? 2'b10 : 2'b11;
          r2 = b_eff[2] ? 2'b11 : 2'b01;
        end else begin
          l2 = a_eff[2] ? 2'b01 : 2'b11;
          r2 = b_eff[2] ? 2'b11 : 2'b10;
        end
        left  = {6'h0, l2};
        right = {6'h0, r2};
      end
      default: begin
        if (le) begin
          left  = 8'hFF << a_eff[2:0];
          right = 8'hFF >> (3'd7 - b_eff[2:0]);
        end else begin
          left  = 8'hFF >> a_eff[2:0];
          right = 8'hFF << (3'd7 - b_eff[2:0]);
        end
      end
    endcase
  end

  assign mask8 = same_blk ? (left & right) : left;

  logic [AW-1:0] diff64;
  logic [HW-1:0] diff32;
  logic [3:0]    f64, f32;

  assign diff64 = addr_a - addr_b;
  assign diff32 = addr_a[HW-1:0] - addr_b[HW-1:0];
  assign f64 = {diff64[AW-1], diff64 == '0,
                (addr_a[AW-1] ^ addr_b[AW-1]) & (diff64[AW-1] ^ addr_a[AW-1]),
                addr_a < addr_b};
  assign f32 = {diff32[HW-1], diff32 == '0,
                (addr_a[HW-1] ^ addr_b[HW-1]) & (diff32[HW-1] ^ addr_a[HW-1]),
                addr_a[HW-1:0] < addr_b[HW-1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      flags_valid <= 1'b0;
      mask_out    <= '0;
      flags32     <= 4'h0;
      flags64     <= 4'h0;
    end else begin
      out_valid   <= in_valid;
      flags_valid <= in_valid & ~op[0];
      if (in_valid) begin
        mask_out <= {{(AW-8){1'b0}}, mask8};
        flags32  <= op[0] ? 4'h0 : f32;
        flags64  <= op[0] ? 4'h0 : f64;
      end
    end
  end

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R12
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !flags_valid); // R12
  AST_NOCC_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[0]) |=> (!flags_valid && flags32 == 4'h0 && flags64 == 4'h0)); // R10
  AST_CC_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[0]) |=> flags_valid); // R9
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !op[0]) |=> (flags64[2] == ($past(addr_a) == $past(addr_b)))); // R9
  AST_WORD_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3:2] == 2'b10) |=> (mask_out[AW-1:2] == '0)); // R5
  AST_HALF_MASK_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op[3:2] == 2'b01) |=> (mask_out[AW-1:4] == '0)); // R4
endmodule

// File: tb/edge_mask_gen_test.sv
module edge_mask_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [3:0]  op = 4'h0;
  logic        addr32 = 1'b0;
  logic [63:0] addr_a = '0, addr_b = '0;
  logic        out_valid, flags_valid;
  logic [63:0] mask_out;
  logic [3:0]  flags32, flags64;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  edge_mask_gen uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .addr32(addr32),
    .addr_a(addr_a), .addr_b(addr_b), .out_valid(out_valid), .mask_out(mask_out),
    .flags_valid(flags_valid), .flags32(flags32), .flags64(flags64));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] ref_mask(input logic [3:0] o, input logic [63:0] a,
                                           input logic [63:0] b, input logic m32);
    logic [63:0] ae, be;
    logic [63:0] r;
    int sz, n, ia, ib;
    bit lit;
    ae = m32 ? {32'h0, a[31:0]} : a;
    be = m32 ? {32'h0, b[31:0]} : b;
    sz = (o[3:2] == 2'b11) ? 0 : int'(o[3:2]);
    lit = (o[3:2] == 2'b11) ? 1'b0 : o[1];
    n = 8 >> sz;
    ia = int'(ae[2:0]) >> sz;
    ib = int'(be[2:0]) >> sz;
    r = '0;
    for (int e = 0; e < n; e++) begin
      int pos;
      bit inl, inr;
      pos = lit ? e : n - 1 - e;
      inl = (e >= ia);
      inr = (e <= ib);
      if ((ae >> 3) == (be >> 3)) r[pos] = inl & inr;
      else r[pos] = inl;
    end
    return r;
  endfunction

  function automatic logic [3:0] ref_flags(input logic [63:0] a, input logic [63:0] b, input int w);
    logic [64:0] d;
    logic an, bn, dn;
    if (w == 32) d = {33'h0, a[31:0]} - {33'h0, b[31:0]};
    else d = {1'b0, a} - {1'b0, b};
    an = (w == 32) ? a[31] : a[63];
    bn = (w == 32) ? b[31] : b[63];
    dn = (w == 32) ? d[31] : d[63];
    return {dn,
            (w == 32) ? (d[31:0] == 32'h0) : (d[63:0] == 64'h0),
            (an & ~bn & ~dn) | (~an & bn & dn),
            (w == 32) ? d[32] : d[64]};
  endfunction

  task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b,
                       input logic m32);
    @(negedge clk);
    op = o; addr_a = a; addr_b = b; addr32 = m32; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run_one(input string req, input logic [3:0] o, input logic [63:0] a,
                         input logic [63:0] b, input logic m32);
    issue(o, a, b, m32);
    check({req, " mask"}, mask_out, ref_mask(o, a, b, m32));
    check("R12 out_valid", {63'h0, out_valid}, 64'h1);
  endtask

  task automatic test_reset();
    check("R13 out_valid", {63'h0, out_valid}, 64'h0);
    check("R13 flags_valid", {63'h0, flags_valid}, 64'h0);
    check("R13 mask", mask_out, 64'h0);
    check("R13 flags", {56'h0, flags32, flags64}, 64'h0);
  endtask

  task automatic test_sweep(input logic [1:0] sz, input bit lit, input string req);
    for (int s = 0; s < 8; s++)
      for (int e = 0; e < 8; e++) begin
        logic [3:0] o;
        o = {sz, lit, 1'b1};
        run_one({req, " R7 same"}, o, 64'h1000 + 64'(s), 64'h1000 + 64'(e), 1'b0);
        run_one({req, " R6 diff"}, o, 64'h1000 + 64'(s), 64'h2008 + 64'(e), 1'b0);
      end
  endtask

  task automatic test_tables();
    issue(4'b0001, 64'h10, 64'h17, 1'b0); check("R2 BE8 a0b7", mask_out, 64'hFF);
    issue(4'b0001, 64'h13, 64'h15, 1'b0); check("R2 BE8 a3b5", mask_out, 64'h1C);
    issue(4'b0011, 64'h13, 64'h15, 1'b0); check("R3 LE8 a3b5", mask_out, 64'h38);
    issue(4'b0011, 64'h17, 64'h10, 1'b0); check("R3 LE8 empty", mask_out, 64'h00);
    issue(4'b0101, 64'h12, 64'h40, 1'b0); check("R4 BE16 left", mask_out, 64'h7);
    issue(4'b0111, 64'h14, 64'h40, 1'b0); check("R4 LE16 left", mask_out, 64'hC);
    issue(4'b1001, 64'h14, 64'h40, 1'b0); check("R5 BE32 left", mask_out, 64'h1);
    issue(4'b1011, 64'h10, 64'h13, 1'b0); check("R5 LE32 same", mask_out, 64'h1);
    issue(4'b1011, 64'h14, 64'h40, 1'b0); check("R6 LE32 left only", mask_out, 64'h2);
    issue(4'b0100, 64'h10, 64'h14, 1'b0); check("R1 size01 means 16-bit", mask_out, 64'hE);
  endtask

  task automatic test_size11();
    issue(4'b1111, 64'h13, 64'h15, 1'b0); check("R11 size11 LE bit ignored", mask_out, 64'h1C);
    issue(4'b1101, 64'h12, 64'h80, 1'b0); check("R11 size11 BE8 left", mask_out, 64'h3F);
  endtask

  task automatic test_addr32();
    logic [63:0] a, b;
    a = 64'hAAAA_0000_0000_1002;
    b = 64'h5555_0000_0000_1005;
    issue(4'b0000, a, b, 1'b1);
    check("R8 m32 same block", mask_out, 64'h3C);
    check("R8 m32 flags64 full", {60'h0, flags64}, {60'h0, ref_flags(a, b, 64)});
    issue(4'b0000, a, b, 1'b0);
    check("R8 no m32 left only", mask_out, 64'h3F);
    check("R8 no m32 flags64", {60'h0, flags64}, {60'h0, ref_flags(a, b, 64)});
  endtask

  task automatic test_flags();
    logic [63:0] pa [6];
    logic [63:0] pb [6];
    pa[0] = 64'h100;                pb[0] = 64'h100;
    pa[1] = 64'h10;                 pb[1] = 64'h20;
    pa[2] = 64'h7FFF_FFFF_FFFF_FFFF; pb[2] = 64'hFFFF_FFFF_FFFF_FFFF;
    pa[3] = 64'h8000_0000_0000_0000; pb[3] = 64'h1;
    pa[4] = 64'h0000_0001_8000_0000; pb[4] = 64'h0000_0000_0000_0001;
    pa[5] = 64'h1234_5678_0000_0000; pb[5] = 64'h0000_0000_0000_0000;
    for (int i = 0; i < 6; i++) begin
      issue(4'b0010, pa[i], pb[i], 1'b0);
      check("R9 flags_valid", {63'h0, flags_valid}, 64'h1);
      check("R9 flags64", {60'h0, flags64}, {60'h0, ref_flags(pa[i], pb[i], 64)});
      check("R9 flags32", {60'h0, flags32}, {60'h0, ref_flags(pa[i], pb[i], 32)});
    end
  endtask

  task automatic test_nocc();
    issue(4'b0011, 64'h10, 64'h20, 1'b0);
    check("R10 flags_valid low", {63'h0, flags_valid}, 64'h0);
    check("R10 flags zero", {56'h0, flags32, flags64}, 64'h0);
    check("R1 bit0 mask still made", mask_out, 64'hFF);
  endtask

  task automatic test_latency();
    @(negedge clk);
    check("R12 idle no valid", {62'h0, out_valid, flags_valid}, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_tables();
    test_sweep(2'b00, 1'b0, "R2");
    test_sweep(2'b00, 1'b1, "R3");
    test_sweep(2'b01, 1'b0, "R4");
    test_sweep(2'b01, 1'b1, "R4");
    test_sweep(2'b10, 1'b0, "R5");
    test_sweep(2'b10, 1'b1, "R5");
    test_sweep(2'b11, 1'b1, "R11");
    test_size11();
    test_addr32();
    test_flags();
    test_nocc();
    test_latency();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule